// File: doc/BRIEF.md
# Battery Charge Ledger

This block keeps the charge-state bookkeeping of a rechargeable-battery fuel gauge. Front-end logic measures current and hands the block one count strobe per unit of charge, discharge or self-discharge. The block also receives the two end-of-discharge comparator results, a charge-complete level from an external charger and a temperature band code. From these it keeps a remaining-capacity counter and a discharge counter. It keeps a learned full capacity, which starts at a programmed value. It also keeps a counter of valid charges made since the last time the capacity was learned.

The learned capacity changes only after a clean discharge from full to empty. The discharge counter is then copied into it on the next valid charge, but never below fifteen sixteenths of the old value. Status flags report whether the current discharge still qualifies for learning, whether the capacity estimate is stale, whether the pack has been reset since it was last full, and whether the empty thresholds have been crossed.

The block acts on at most one event per clock. When several inputs are active together, the one with the highest priority wins.

Top module: `cap_ledger`

## Requirements
- R1: After reset: `nac_o`=0, `dcr_o`=0, `lmd_o`=PFC (default 200), `cpi_o`=0, `vdq_o`=0, `ci_o`=0, `brp_o`=1, `edv1_o`=0, `edvf_o`=0.
- R2: A charge strobe raises `nac_o` by 1. It stops at the ceiling: the ceiling is `lmd_o`, or `lmd_o - (lmd_o>>4)` when `temp_band_i` < 4 (cold). At or above the ceiling, `nac_o` holds.
- R3: A discharge or self-discharge strobe lowers `nac_o` by 1, with a floor at 0.
- R4: A discharge strobe raises `dcr_o` by 1. A self-discharge strobe raises it by 1 only while `nac_o` is nonzero. `dcr_o` saturates at 255.
- R5: A discharge start is the first discharge strobe after reset, after a charge strobe or after charge-complete. If `nac_o` ≥ `lmd_o - (lmd_o>>4)` at the start, `dcr_o` becomes 1, `vdq_o` is set and the self-discharge budget is re-armed. Otherwise `vdq_o` is cleared.
- R6: A valid charge is the second charge strobe in a row with no discharge strobe or charge-complete between them. Each valid charge raises `cpi_o` by 1, saturating at 255. `ci_o` is 1 exactly when `cpi_o` ≥ 64.
- R7: A valid charge while `edv1_o` is set clears `nac_o`. If `vdq_o` is also set, it loads `lmd_o` with `max(dcr_o, lmd_o - (lmd_o>>4))` and clears `cpi_o`.
- R8: `vdq_o` is cleared in three cases: by a valid charge; by the self-discharge strobe that takes the self-discharge count since the discharge start above `nac_o>>4` (sampled at that start); and when `edv1_o` becomes set while the band is cold.
- R9: `done_i` high sets `nac_o` to `lmd_o` and sets `vdq_o`.
- R10: Priority within one cycle is `done_i`, then discharge, then self-discharge, then charge. The lower-priority strobes in that cycle are ignored.
- R11: `brp_o` clears in two cases: when a charge strobe leaves `nac_o` equal to `lmd_o`, or on a valid charge while `edv1_o` is set. It never sets again outside reset.
- R12: `edv1_o` and `edvf_o` set when their comparator input is high. They hold until a valid charge clears them, and a high input wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chg_stb_i | input | 1 | One charge count |
| dsg_stb_i | input | 1 | One discharge count |
| sdc_stb_i | input | 1 | One self-discharge count |
| done_i | input | 1 | Charge complete from external charger |
| edv1_i | input | 1 | First end-of-discharge comparator result |
| edvf_i | input | 1 | Final end-of-discharge comparator result |
| temp_band_i | input | TB_W (4) | Temperature band in 10 °C steps; below 4 is under 0 °C |
| nac_o | output | CNT_W (8) | Remaining capacity count |
| dcr_o | output | CNT_W (8) | Discharge count |
| lmd_o | output | CNT_W (8) | Learned full capacity |
| cpi_o | output | CPI_W (8) | Valid charges since last learn |
| vdq_o | output | 1 | Discharge qualifies for learning |
| ci_o | output | 1 | Capacity estimate stale |
| brp_o | output | 1 | Reset since last full |
| edv1_o | output | 1 | First empty threshold latched |
| edvf_o | output | 1 | Final empty threshold latched |

## Verification
Every result except `ci_o` is a register that updates on the clock edge that samples the inputs of that cycle, so each effect is due exactly one cycle after its stimulus. `ci_o` follows `cpi_o` combinationally in the same cycle. The bench drives one event per cycle on the falling edge. It advances its arithmetic model with the same inputs, and compares every output at the next falling edge, half a period after the edge that updated the registers. Directed sequences pin constant expectations at each step of a learn cycle, a cold ceiling, counter floors and saturations. Random sweeps in warm and cold bands then cover the mixed orderings.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_DONE,
    ACT_DSG,
    ACT_SDC,
    ACT_CHG
  } act_e;
endpackage

// File: rtl/cap_evt_arb.sv
module cap_evt_arb
  import cap_pkg::*;
#(
  parameter int RUN_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_stb_i,
  input  logic dsg_stb_i,
  input  logic sdc_stb_i,
  input  logic done_i,
  output act_e act_o,
  output logic vchg_o,
  output logic dstart_o
);
  localparam logic [RUN_W-1:0] RUN_QUAL = RUN_W'(2);

  logic [RUN_W-1:0] run_q;
  logic             dact_q;

  always_comb begin
    if (done_i)         act_o = ACT_DONE;
    else if (dsg_stb_i) act_o = ACT_DSG;
    else if (sdc_stb_i) act_o = ACT_SDC;
    else if (chg_stb_i) act_o = ACT_CHG;
    else                act_o = ACT_NONE;
  end

  // second consecutive charge strobe qualifies
  assign vchg_o   = (act_o == ACT_CHG) && (run_q == RUN_QUAL - 1'b1);
  assign dstart_o = (act_o == ACT_DSG) && !dact_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      dact_q <= 1'b0;
    end else begin
      unique case (act_o)
        ACT_DONE: begin
          run_q  <= '0;
          dact_q <= 1'b0;
        end
        ACT_DSG: begin
          run_q  <= '0;
          dact_q <= 1'b1;
        end
        ACT_CHG: begin
          dact_q <= 1'b0;
          if (run_q != RUN_QUAL) run_q <= run_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cap_nac_ctr.sv
module cap_nac_ctr
  import cap_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  act_e             act_i,
  input  logic             vchg_i,
  input  logic             edv1_q_i,
  input  logic [CNT_W-1:0] lmd_i,
  input  logic [CNT_W-1:0] cap_i,
  output logic [CNT_W-1:0] nac_o,
  output logic [CNT_W-1:0] nac_next_o
);
  logic [CNT_W-1:0] nac_q, nac_d;

  always_comb begin
    nac_d = nac_q;
    unique case (act_i)
      ACT_DONE: nac_d = lmd_i;
      ACT_DSG, ACT_SDC: if (nac_q != '0) nac_d = nac_q - 1'b1;
      ACT_CHG: begin
        if (vchg_i && edv1_q_i)  nac_d = '0;
        else if (nac_q < cap_i)  nac_d = nac_q + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nac_q <= '0;
    else         nac_q <= nac_d;
  end

  assign nac_o      = nac_q;
  assign nac_next_o = nac_d;
endmodule

// File: rtl/cap_learn.sv
module cap_learn
  import cap_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CPI_W = 8,
  parameter int PFC   = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  act_e             act_i,
  input  logic             vchg_i,
  input  logic             dstart_i,
  input  logic             edv1_q_i,
  input  logic             edv1_set_i,
  input  logic             cold_i,
  input  logic [CNT_W-1:0] nac_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] dcr_o,
  output logic [CNT_W-1:0] lmd_o,
  output logic [CPI_W-1:0] cpi_o,
  output logic             vdq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CPI_W-1:0] CPI_MAX = '1;
  localparam int               SD_SH   = 4;

  logic [CNT_W-1:0] dcr_q, dcr_d, lmd_q, lmd_d, sd_cnt_q, sd_cnt_d, sd_lim_q, sd_lim_d;
  logic [CNT_W-1:0] dcr_inc;
  logic [CPI_W-1:0] cpi_q, cpi_d, cpi_inc;
  logic             vdq_q, vdq_d;

  assign dcr_inc = (dcr_q == CNT_MAX) ? dcr_q : dcr_q + 1'b1;
  assign cpi_inc = (cpi_q == CPI_MAX) ? cpi_q : cpi_q + 1'b1;

  always_comb begin
    dcr_d    = dcr_q;
    lmd_d    = lmd_q;
    cpi_d    = cpi_q;
    vdq_d    = vdq_q;
    sd_cnt_d = sd_cnt_q;
    sd_lim_d = sd_lim_q;
    unique case (act_i)
      ACT_DONE: begin
        vdq_d    = 1'b1;
        sd_cnt_d = '0;
        sd_lim_d = lmd_q >> SD_SH;
      end
      ACT_DSG: begin
        if (dstart_i && nac_i >= thr_i) begin
          dcr_d    = CNT_W'(1);
          vdq_d    = 1'b1;
          sd_cnt_d = '0;
          sd_lim_d = nac_i >> SD_SH;
        end else begin
          dcr_d = dcr_inc;
          if (dstart_i) vdq_d = 1'b0;
        end
      end
      ACT_SDC: begin
        if (nac_i != '0) dcr_d = dcr_inc;
        if (sd_cnt_q != CNT_MAX) sd_cnt_d = sd_cnt_q + 1'b1;
        if (sd_cnt_q >= sd_lim_q) vdq_d = 1'b0;
      end
      ACT_CHG: begin
        if (vchg_i) begin
          cpi_d = cpi_inc;
          vdq_d = 1'b0;
          if (edv1_q_i && vdq_q) begin
            lmd_d = (dcr_q < thr_i) ? thr_i : dcr_q;
            cpi_d = '0;
          end
        end
      end
      default: ;
    endcase
    if (edv1_set_i && cold_i && act_i != ACT_DONE) vdq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcr_q    <= '0;
      lmd_q    <= CNT_W'(PFC);
      cpi_q    <= '0;
      vdq_q    <= 1'b0;
      sd_cnt_q <= '0;
      sd_lim_q <= '0;
    end else begin
      dcr_q    <= dcr_d;
      lmd_q    <= lmd_d;
      cpi_q    <= cpi_d;
      vdq_q    <= vdq_d;
      sd_cnt_q <= sd_cnt_d;
      sd_lim_q <= sd_lim_d;
    end
  end

  assign dcr_o = dcr_q;
  assign lmd_o = lmd_q;
  assign cpi_o = cpi_q;
  assign vdq_o = vdq_q;
endmodule

// File: rtl/cap_flags.sv
module cap_flags
  import cap_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int CPI_W  = 8,
  parameter int CI_LIM = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  act_e             act_i,
  input  logic             vchg_i,
  input  logic             edv1_i,
  input  logic             edvf_i,
  input  logic [CNT_W-1:0] nac_next_i,
  input  logic [CNT_W-1:0] lmd_i,
  input  logic [CPI_W-1:0] cpi_i,
  output logic             edv1_o,
  output logic             edvf_o,
  output logic             brp_o,
  output logic             ci_o
);
  logic edv1_q, edvf_q, brp_q, brp_clr;

  assign brp_clr = ((act_i == ACT_CHG) && (nac_next_i == lmd_i)) || (vchg_i && edv1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edv1_q <= 1'b0;
      edvf_q <= 1'b0;
      brp_q  <= 1'b1;
    end else begin
      if (edv1_i)      edv1_q <= 1'b1;
      else if (vchg_i) edv1_q <= 1'b0;
      if (edvf_i)      edvf_q <= 1'b1;
      else if (vchg_i) edvf_q <= 1'b0;
      if (brp_clr)     brp_q  <= 1'b0;
    end
  end

  assign edv1_o = edv1_q;
  assign edvf_o = edvf_q;
  assign brp_o  = brp_q;
  assign ci_o   = cpi_i >= CPI_W'(CI_LIM);
endmodule

// File: rtl/cap_ledger.sv
module cap_ledger
  import cap_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int CPI_W     = 8,
  parameter int TB_W      = 4,
  parameter int COLD_BAND = 4,
  parameter int PFC       = 200,
  parameter int CI_LIM    = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chg_stb_i,
  input  logic             dsg_stb_i,
  input  logic             sdc_stb_i,
  input  logic             done_i,
  input  logic             edv1_i,
  input  logic             edvf_i,
  input  logic [TB_W-1:0]  temp_band_i,
  output logic [CNT_W-1:0] nac_o,
  output logic [CNT_W-1:0] dcr_o,
  output logic [CNT_W-1:0] lmd_o,
  output logic [CPI_W-1:0] cpi_o,
  output logic             vdq_o,
  output logic             ci_o,
  output logic             brp_o,
  output logic             edv1_o,
  output logic             edvf_o
);
  localparam int THR_SH = 4;  // 15/16 stands in for 0.94

  act_e             act;
  logic             vchg, dstart, cold;
  logic [CNT_W-1:0] thr, cap, nac_next;

  assign thr  = lmd_o - (lmd_o >> THR_SH);
  assign cold = temp_band_i < TB_W'(COLD_BAND);
  assign cap  = cold ? thr : lmd_o;

  cap_evt_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chg_stb_i (chg_stb_i),
    .dsg_stb_i (dsg_stb_i),
    .sdc_stb_i (sdc_stb_i),
    .done_i    (done_i),
    .act_o     (act),
    .vchg_o    (vchg),
    .dstart_o  (dstart)
  );

  cap_nac_ctr #(.CNT_W(CNT_W)) u_nac (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .vchg_i     (vchg),
    .edv1_q_i   (edv1_o),
    .lmd_i      (lmd_o),
    .cap_i      (cap),
    .nac_o      (nac_o),
    .nac_next_o (nac_next)
  );

  cap_learn #(.CNT_W(CNT_W), .CPI_W(CPI_W), .PFC(PFC)) u_learn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .vchg_i     (vchg),
    .dstart_i   (dstart),
    .edv1_q_i   (edv1_o),
    .edv1_set_i (edv1_i && !edv1_o),
    .cold_i     (cold),
    .nac_i      (nac_o),
    .thr_i      (thr),
    .dcr_o      (dcr_o),
    .lmd_o      (lmd_o),
    .cpi_o      (cpi_o),
    .vdq_o      (vdq_o)
  );

  cap_flags #(.CNT_W(CNT_W), .CPI_W(CPI_W), .CI_LIM(CI_LIM)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .vchg_i     (vchg),
    .edv1_i     (edv1_i),
    .edvf_i     (edvf_i),
    .nac_next_i (nac_next),
    .lmd_i      (lmd_o),
    .cpi_i      (cpi_o),
    .edv1_o     (edv1_o),
    .edvf_o     (edvf_o),
    .brp_o      (brp_o),
    .ci_o       (ci_o)
  );
endmodule

// File: rtl/cap_ledger_chk.sv
module cap_ledger_chk #(
  parameter int CNT_W = 8,
  parameter int CPI_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chg_stb_i,
  input logic             dsg_stb_i,
  input logic             done_i,
  input logic [CNT_W-1:0] nac_o,
  input logic [CNT_W-1:0] dcr_o,
  input logic [CNT_W-1:0] lmd_o,
  input logic [CPI_W-1:0] cpi_o,
  input logic             vdq_o,
  input logic             brp_o,
  input logic             edv1_o
);
  p_nac_le_lmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nac_o <= lmd_o);

  p_nac_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsg_stb_i && !done_i) |=>
      nac_o == (($past(nac_o) == '0) ? '0 : $past(nac_o) - 1'b1));

  p_dcr_grow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (dcr_o >= $past(dcr_o)) || (dcr_o == CNT_W'(1)));

  p_cpi_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(cpi_o) || (cpi_o == '0) || (cpi_o == $past(cpi_o) + 1'b1));

  p_lmd_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(lmd_o) || (lmd_o >= $past(lmd_o) - ($past(lmd_o) >> 4)));

  p_done_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (nac_o == $past(lmd_o)) && vdq_o);

  p_brp_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brp_o |=> !brp_o);

  p_edv_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edv1_o && !chg_stb_i) |=> edv1_o);
endmodule

bind cap_ledger cap_ledger_chk #(.CNT_W(CNT_W), .CPI_W(CPI_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chg_stb_i (chg_stb_i),
  .dsg_stb_i (dsg_stb_i),
  .done_i    (done_i),
  .nac_o     (nac_o),
  .dcr_o     (dcr_o),
  .lmd_o     (lmd_o),
  .cpi_o     (cpi_o),
  .vdq_o     (vdq_o),
  .brp_o     (brp_o),
  .edv1_o    (edv1_o)
);

// File: tb/cap_ledger_test.sv
module cap_ledger_test;
  localparam int PFC = 200;
  localparam int MX  = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       c = 0, d = 0, s = 0, dn = 0, e1 = 0, ef = 0;
  logic [3:0] tb = 4'd6;
  logic [7:0] nac, dcr, lmd, cpi;
  logic       vdq, ci, brp, edv1, edvf;

  int n_chk = 0, n_fail = 0;
  int m_nac, m_dcr, m_lmd, m_cpi, m_vdq, m_brp, m_e1, m_ef, m_run, m_dact, m_sdc, m_sdl;

  always #4 clk = ~clk;

  cap_ledger uut (
    .clk_i(clk), .rst_ni(rst_n), .chg_stb_i(c), .dsg_stb_i(d), .sdc_stb_i(s),
    .done_i(dn), .edv1_i(e1), .edvf_i(ef), .temp_band_i(tb),
    .nac_o(nac), .dcr_o(dcr), .lmd_o(lmd), .cpi_o(cpi), .vdq_o(vdq),
    .ci_o(ci), .brp_o(brp), .edv1_o(edv1), .edvf_o(edvf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2 R3 nac", int'(nac), m_nac);
    chk("R4 dcr", int'(dcr), m_dcr);
    chk("R7 lmd", int'(lmd), m_lmd);
    chk("R6 cpi", int'(cpi), m_cpi);
    chk("R6 ci", int'(ci), (m_cpi >= 64) ? 1 : 0);
    chk("R8 vdq", int'(vdq), m_vdq);
    chk("R11 brp", int'(brp), m_brp);
    chk("R12 edv1", int'(edv1), m_e1);
    chk("R12 edvf", int'(edvf), m_ef);
  endtask

  task automatic model_reset();
    m_nac = 0; m_dcr = 0; m_lmd = PFC; m_cpi = 0; m_vdq = 0; m_brp = 1;
    m_e1 = 0; m_ef = 0; m_run = 0; m_dact = 0; m_sdc = 0; m_sdl = 0;
  endtask

  // one-cycle model built from the requirements
  task automatic model_step();
    int thr, cap, n_nac, n_dcr, n_lmd, n_cpi, n_vdq, n_run, n_dact, n_sdc, n_sdl;
    bit cold, vchg, dstart;
    int act;  // 0 none 1 done 2 dsg 3 sdc 4 chg
    act = dn ? 1 : d ? 2 : s ? 3 : c ? 4 : 0;
    thr = m_lmd - (m_lmd >> 4);
    cold = tb < 4;
    cap = cold ? thr : m_lmd;
    vchg = (act == 4) && (m_run == 1);
    dstart = (act == 2) && (m_dact == 0);
    n_nac = m_nac; n_dcr = m_dcr; n_lmd = m_lmd; n_cpi = m_cpi; n_vdq = m_vdq;
    n_run = m_run; n_dact = m_dact; n_sdc = m_sdc; n_sdl = m_sdl;
    case (act)
      1: begin
        n_nac = m_lmd; n_vdq = 1; n_run = 0; n_dact = 0; n_sdc = 0; n_sdl = m_lmd >> 4;
      end
      2: begin
        n_nac = (m_nac > 0) ? m_nac - 1 : 0; n_run = 0; n_dact = 1;
        if (dstart && m_nac >= thr) begin
          n_dcr = 1; n_vdq = 1; n_sdc = 0; n_sdl = m_nac >> 4;
        end else begin
          n_dcr = (m_dcr < MX) ? m_dcr + 1 : MX;
          if (dstart) n_vdq = 0;
        end
      end
      3: begin
        n_nac = (m_nac > 0) ? m_nac - 1 : 0;
        if (m_nac != 0) n_dcr = (m_dcr < MX) ? m_dcr + 1 : MX;
        n_sdc = (m_sdc < MX) ? m_sdc + 1 : MX;
        if (m_sdc + 1 > m_sdl) n_vdq = 0;
      end
      4: begin
        n_dact = 0;
        if (m_run < 2) n_run = m_run + 1;
        if (vchg) begin
          n_cpi = (m_cpi < MX) ? m_cpi + 1 : MX;
          n_vdq = 0;
        end
        if (vchg && m_e1 == 1) begin
          n_nac = 0;
          if (m_vdq == 1) begin
            n_lmd = (m_dcr < thr) ? thr : m_dcr;
            n_cpi = 0;
          end
        end else if (m_nac < cap) n_nac = m_nac + 1;
      end
      default: ;
    endcase
    if (e1 && m_e1 == 0 && cold && act != 1) n_vdq = 0;
    if ((act == 4 && n_nac == m_lmd) || (vchg && m_e1 == 1)) m_brp = 0;
    m_e1 = e1 ? 1 : (vchg ? 0 : m_e1);
    m_ef = ef ? 1 : (vchg ? 0 : m_ef);
    m_nac = n_nac; m_dcr = n_dcr; m_lmd = n_lmd; m_cpi = n_cpi; m_vdq = n_vdq;
    m_run = n_run; m_dact = n_dact; m_sdc = n_sdc; m_sdl = n_sdl;
  endtask

  task automatic cyc(input bit c_, input bit d_, input bit s_, input bit dn_,
                     input bit e1_, input bit ef_, input logic [3:0] tb_);
    c = c_; d = d_; s = s_; dn = dn_; e1 = e1_; ef = ef_; tb = tb_;
    model_step();
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cpi0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cmp_all();
    chk("R1 lmd", int'(lmd), PFC);
    chk("R1 brp", int'(brp), 1);
    // R2 warm charge, R6 second charge qualifies
    repeat (3) cyc(1, 0, 0, 0, 0, 0, 6);
    chk("R2 nac", int'(nac), 3);
    chk("R6 cpi", int'(cpi), 1);
    // R9 charge complete
    cyc(0, 0, 0, 1, 0, 0, 6);
    chk("R9 nac", int'(nac), 200);
    chk("R9 vdq", int'(vdq), 1);
    cyc(1, 0, 0, 0, 0, 0, 6);
    chk("R11 brp", int'(brp), 0);
    // R10 discharge beats charge, R5 start at full
    cyc(1, 1, 0, 0, 0, 0, 6);
    chk("R10 nac", int'(nac), 199);
    chk("R5 dcr", int'(dcr), 1);
    repeat (149) cyc(0, 1, 0, 0, 0, 0, 6);
    cyc(0, 1, 0, 0, 1, 0, 6);
    chk("R12 edv1 set", int'(edv1), 1);
    chk("R4 dcr", int'(dcr), 151);
    cyc(1, 0, 0, 0, 0, 0, 6);
    cyc(1, 0, 0, 0, 0, 0, 6);
    chk("R7 lmd floor", int'(lmd), 188);
    chk("R7 nac", int'(nac), 0);
    chk("R7 cpi", int'(cpi), 0);
    chk("R12 edv1 clr", int'(edv1), 0);
    // R8 self-discharge budget: 188>>4 = 11
    cyc(0, 0, 0, 1, 0, 0, 6);
    cyc(0, 1, 0, 0, 0, 0, 6);
    repeat (11) cyc(0, 0, 1, 0, 0, 0, 6);
    chk("R8 vdq kept", int'(vdq), 1);
    cyc(0, 0, 1, 0, 0, 0, 6);
    chk("R8 vdq clr", int'(vdq), 0);
    // R2 cold ceiling 188-11=177
    cyc(0, 0, 0, 1, 0, 0, 2);
    repeat (20) cyc(0, 1, 0, 0, 0, 0, 2);
    repeat (15) cyc(1, 0, 0, 0, 0, 0, 2);
    chk("R2 cold cap", int'(nac), 177);
    // R3 floor, R4 saturation and self-discharge at empty
    repeat (300) cyc(0, 1, 0, 0, 0, 0, 6);
    chk("R3 floor", int'(nac), 0);
    chk("R4 sat", int'(dcr), 255);
    cyc(0, 0, 1, 0, 0, 0, 6);
    chk("R4 sdc at empty", int'(dcr), 255);
    // R6 CI threshold
    cpi0 = int'(cpi);
    for (int i = 0; i < 70; i++) begin
      cyc(0, 1, 0, 0, 0, 0, 6);
      cyc(1, 0, 0, 0, 0, 0, 6);
      cyc(1, 0, 0, 0, 0, 0, 6);
    end
    chk("R6 cpi", int'(cpi), (cpi0 + 70 > MX) ? MX : cpi0 + 70);
    chk("R6 ci", int'(ci), 1);
    // mixed sweeps over warm and cold bands
    for (int b = 0; b < 4; b++) begin
      logic [3:0] band;
      band = (b == 0) ? 4'd2 : (b == 1) ? 4'd6 : (b == 2) ? 4'd9 : 4'd3;
      for (int k = 0; k < 3000; k++) begin
        int r;
        r = $urandom_range(0, 99);
        cyc(r < 45 || (r % 7 == 0), (r >= 45 && r < 75) || (r % 11 == 0),
            r >= 75 && r < 90, r == 99, m_nac < 15 && r % 3 == 0,
            m_nac < 5 && r % 5 == 0, band);
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule